// File: doc/BRIEF.md
# Three-Port Bridge Address Router

This block chooses the destination of each transaction entering a bridge that has one upstream (primary) port and two downstream (secondary) ports. Each request gives the port it came in on, whether it is an I/O or a memory access, and a 32-bit address. The block compares the address with address windows held for each secondary port. It also applies two command enables. One clock later it reports a one-hot destination or an ignore flag, together with the address, which passes through unchanged.

Each secondary port owns three windows: one I/O window, one non-prefetchable memory window and one prefetchable memory window. That gives six windows in total. An I/O request is compared only with I/O windows. A memory request is compared with both memory windows of each port.

Traffic from the primary port goes down to the secondary port that claims the address. Traffic from a secondary port goes up to the primary port unless the other secondary port claims the address, in which case it crosses directly between the two secondary ports. Configuration is loaded through a single-cycle register-write port.

Top module: `tpr_router_top`

## Requirements
- R1: A window hits when base <= address <= limit (unsigned). A window whose limit is below its base never hits. After reset every window has base all-ones and limit zero, so no window hits.
- R2: A request from port 0 (primary) goes to secondary 1 (out_dest bit 1) or secondary 2 (out_dest bit 2) when it hits a window of the matching kind on that port. I/O requests use the I/O window. Memory requests use either memory window.
- R3: When a primary request hits windows of both secondary ports, secondary 1 wins.
- R4: A primary I/O request is ignored while command bit 0 (I/O enable) is clear. A primary request that hits no window is ignored. Primary memory requests do not depend on command bit 0.
- R5: While command bit 1 (master enable) is clear, every request from port 1 or port 2 is ignored.
- R6: With master enable set, a secondary request that hits no window on either secondary port goes to the primary port (out_dest bit 0).
- R7: A request from a secondary port that hits a window of its own port is ignored, even when it also hits the other port's window.
- R8: With master enable set, a request from one secondary port that hits only the other port's windows goes to that other port.
- R9: out_valid rises exactly one clock after each req_valid and is low otherwise. out_addr equals the request's address.
- R10: While out_valid is high, either out_ignore is set and out_dest is zero, or out_ignore is clear and exactly one out_dest bit is set.
- R11: Register map, written with cfg_we:
  - Address 0 is the command register: bit 0 is the I/O enable, bit 1 is the master enable.
  - Window addresses have bit 4 set. Bit 3 selects the port (0 = secondary 1). Bits 2:1 select the kind (0 = I/O, 1 = non-prefetchable memory, 2 = prefetchable memory). Bit 0 selects base (0) or limit (1).
  - Any other address, including kind 3, is ignored.
  - A write takes effect for requests presented on the following cycle, not for a request presented on the same cycle.
  - A request from port code 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Request strobe |
| req_port | input | 2 | Initiating port: 0 primary, 1 secondary 1, 2 secondary 2 |
| req_is_io | input | 1 | 1 = I/O request, 0 = memory request |
| req_addr | input | 32 | Request address |
| out_valid | output | 1 | Decision valid, one cycle after req_valid |
| out_dest | output | 3 | One-hot destination: bit 0 primary, bit 1 secondary 1, bit 2 secondary 2 |
| out_ignore | output | 1 | Request is not forwarded |
| out_addr | output | 32 | Forwarded address, unchanged |

## Verification
The bench sweeps every port code, both request kinds and all four enable combinations. It does this over addresses placed at each window edge and one step outside it, for two window layouts: one with overlapping windows, and one with an empty window, a single-address window and windows touching address zero and all-ones.

These cases target specific faults:
- An off-by-one comparison would either drop the boundary address or claim the address next to it.
- A reversed priority would send overlapping primary traffic to secondary 2.
- A design that skips the own-port check would bounce local traffic to the other port or upstream.
- A missing type match would let I/O requests hit memory windows.

Directed cases also target register decoding. A write and a request on the same cycle must use the old setting, and writes to unmapped addresses must leave routing untouched. A design that applies writes combinationally, or decodes addresses loosely, fails these.

// File: rtl/tpr_pkg.sv
package tpr_pkg;
  localparam int NSEC   = 2;
  localparam int NKIND  = 3;
  localparam int NDEST  = 3;
  localparam int CFG_AW = 5;

  localparam int KIND_IO   = 0;
  localparam int KIND_MEM  = 1;
  localparam int KIND_PREF = 2;

  localparam int DST_PRI = 0;
  localparam int DST_S1  = 1;
  localparam int DST_S2  = 2;

  localparam logic [CFG_AW-1:0] CMD_ADDR = '0;

  typedef enum logic [1:0] {
    SRC_PRI = 2'd0,
    SRC_S1  = 2'd1,
    SRC_S2  = 2'd2,
    SRC_BAD = 2'd3
  } src_e;

  // Register address of a window field: {1, port, kind[1:0], limit_sel}
  function automatic logic [CFG_AW-1:0] win_reg_addr(input int port, input int kind,
                                                     input logic is_limit);
    logic [CFG_AW-1:0] a;
    a = '0;
    a[4]   = 1'b1;
    a[3]   = (port != 0);
    a[2:1] = kind[1:0];
    a[0]   = is_limit;
    return a;
  endfunction
endpackage

// File: rtl/tpr_cfg_regs.sv
module tpr_cfg_regs
  import tpr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cfg_we,
  input  logic [CFG_AW-1:0]                   cfg_addr,
  input  logic [ADDR_W-1:0]                   cfg_wdata,
  output logic [NSEC-1:0][NKIND-1:0][ADDR_W-1:0] win_base,
  output logic [NSEC-1:0][NKIND-1:0][ADDR_W-1:0] win_limit,
  output logic                                io_en,
  output logic                                mst_en
);
  logic cmd_sel;
  assign cmd_sel = cfg_we && (cfg_addr == CMD_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_en  <= 1'b0;
      mst_en <= 1'b0;
    end else if (cmd_sel) begin
      io_en  <= cfg_wdata[0];
      mst_en <= cfg_wdata[1];
    end
  end

  for (genvar p = 0; p < NSEC; p++) begin : g_port
    for (genvar k = 0; k < NKIND; k++) begin : g_kind
      logic base_sel, limit_sel;
      assign base_sel  = cfg_we && (cfg_addr == win_reg_addr(p, k, 1'b0));
      assign limit_sel = cfg_we && (cfg_addr == win_reg_addr(p, k, 1'b1));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          win_base[p][k]  <= '1;
          win_limit[p][k] <= '0;
        end else begin
          if (base_sel)  win_base[p][k]  <= cfg_wdata;
          if (limit_sel) win_limit[p][k] <= cfg_wdata;
        end
      end
    end
  end

  // R11
  cmd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == CMD_ADDR) |=> (io_en == $past(cfg_wdata[0]) && mst_en == $past(cfg_wdata[1])));

  // R11
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_addr == CMD_ADDR) |=> $stable({io_en, mst_en}));
endmodule

// File: rtl/tpr_window_match.sv
module tpr_window_match #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] limit,
  output logic              hit
);
  function automatic logic inside_range(input logic [ADDR_W-1:0] a,
                                        input logic [ADDR_W-1:0] lo,
                                        input logic [ADDR_W-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  assign hit = inside_range(addr, base, limit);
endmodule

// File: rtl/tpr_route_decide.sv
module tpr_route_decide
  import tpr_pkg::*;
(
  input  logic [1:0]       src,
  input  logic             is_io,
  input  logic [NSEC-1:0]  port_hit,
  input  logic             io_en,
  input  logic             mst_en,
  output logic [NDEST-1:0] dest,
  output logic             ignore
);
  logic own_hit, oth_hit;
  logic pri_allowed;

  assign pri_allowed = !(is_io && !io_en);

  always_comb begin
    own_hit = 1'b0;
    oth_hit = 1'b0;
    case (src)
      SRC_S1: begin own_hit = port_hit[0]; oth_hit = port_hit[1]; end
      SRC_S2: begin own_hit = port_hit[1]; oth_hit = port_hit[0]; end
      default: ;
    endcase
  end

  always_comb begin
    dest = '0;
    case (src)
      SRC_PRI: begin
        if (pri_allowed) begin
          if (port_hit[0])      dest[DST_S1] = 1'b1;
          else if (port_hit[1]) dest[DST_S2] = 1'b1;
        end
      end
      SRC_S1, SRC_S2: begin
        if (mst_en && !own_hit) begin
          if (oth_hit) begin
            if (src == SRC_S1) dest[DST_S2] = 1'b1;
            else               dest[DST_S1] = 1'b1;
          end else begin
            dest[DST_PRI] = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  assign ignore = (dest == '0);
endmodule

// File: rtl/tpr_router_top.sv
module tpr_router_top
  import tpr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [4:0]        cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              req_valid,
  input  logic [1:0]        req_port,
  input  logic              req_is_io,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              out_valid,
  output logic [2:0]        out_dest,
  output logic              out_ignore,
  output logic [ADDR_W-1:0] out_addr
);
  logic [NSEC-1:0][NKIND-1:0][ADDR_W-1:0] win_base, win_limit;
  logic io_en, mst_en;
  logic [NSEC-1:0][NKIND-1:0] hit_raw;
  logic [NSEC-1:0] port_hit;
  logic [NDEST-1:0] nxt_dest;
  logic nxt_ignore;

  tpr_cfg_regs #(.ADDR_W(ADDR_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .win_base(win_base), .win_limit(win_limit),
    .io_en(io_en), .mst_en(mst_en)
  );

  for (genvar p = 0; p < NSEC; p++) begin : g_match
    for (genvar k = 0; k < NKIND; k++) begin : g_win
      tpr_window_match #(.ADDR_W(ADDR_W)) win_i (
        .addr(req_addr), .base(win_base[p][k]), .limit(win_limit[p][k]),
        .hit(hit_raw[p][k])
      );

      // R1
      empty_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit_raw[p][k]) |-> (win_base[p][k] <= win_limit[p][k]));
    end
    assign port_hit[p] = req_is_io ? hit_raw[p][KIND_IO]
                                   : (hit_raw[p][KIND_MEM] | hit_raw[p][KIND_PREF]);
  end

  tpr_route_decide decide_i (
    .src(req_port), .is_io(req_is_io), .port_hit(port_hit),
    .io_en(io_en), .mst_en(mst_en), .dest(nxt_dest), .ignore(nxt_ignore)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_dest   <= '0;
      out_ignore <= 1'b0;
      out_addr   <= '0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_dest   <= nxt_dest;
        out_ignore <= nxt_ignore;
        out_addr   <= req_addr;
      end
    end
  end

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);
  // R9
  addr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (out_addr == $past(req_addr)));
  // R10
  dest_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_dest) == (out_ignore ? 0 : 1)));
  // R5
  mst_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_port == SRC_S1 || req_port == SRC_S2) && !mst_en) |=> out_ignore);
  // R4
  io_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_port == SRC_PRI && req_is_io && !io_en) |=> out_ignore);
  // R7
  own_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_port == SRC_S1 && port_hit[0]) |=> out_ignore);
  // R3
  pri_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_port == SRC_PRI && port_hit[0] && (!req_is_io || io_en))
      |=> out_dest[DST_S1]);
endmodule

// File: tb/tpr_router_top_tb_top.sv
module tpr_router_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [4:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic req_valid = 1'b0;
  logic [1:0] req_port = '0;
  logic req_is_io = 1'b0;
  logic [31:0] req_addr = '0;
  logic out_valid;
  logic [2:0] out_dest;
  logic out_ignore;
  logic [31:0] out_addr;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_base [2][3];
  logic [31:0] m_lim  [2][3];
  bit m_io_en = 0;
  bit m_mst = 0;

  always #2 clk = ~clk;

  tpr_router_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_port(req_port),
    .req_is_io(req_is_io), .req_addr(req_addr), .out_valid(out_valid),
    .out_dest(out_dest), .out_ignore(out_ignore), .out_addr(out_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit in_win(int p, int k, logic [31:0] a);
    return (a >= m_base[p][k]) && (a <= m_lim[p][k]);
  endfunction

  function automatic bit port_claims(int p, bit io, logic [31:0] a);
    if (io) return in_win(p, 0, a);
    return in_win(p, 1, a) || in_win(p, 2, a);
  endfunction

  // expected {ignore, dest[2:0]} and the requirement it exercises
  function automatic logic [3:0] model(int port, bit io, logic [31:0] a, output string tag);
    bit h1, h2;
    h1 = port_claims(0, io, a);
    h2 = port_claims(1, io, a);
    if (port == 0) begin
      if (io && !m_io_en) begin tag = "R4 io-disabled"; return 4'b1000; end
      if (h1 && h2) begin tag = "R3 priority"; return 4'b0010; end
      if (h1) begin tag = "R2 down-s1"; return 4'b0010; end
      if (h2) begin tag = "R2 down-s2"; return 4'b0100; end
      tag = "R4 no-hit";
      return 4'b1000;
    end
    if (port == 3) begin tag = "R11 bad-port"; return 4'b1000; end
    if (!m_mst) begin tag = "R5 master-off"; return 4'b1000; end
    if ((port == 1 && h1) || (port == 2 && h2)) begin tag = "R7 own"; return 4'b1000; end
    if (port == 1 && h2) begin tag = "R8 cross-to-s2"; return 4'b0100; end
    if (port == 2 && h1) begin tag = "R8 cross-to-s1"; return 4'b0010; end
    tag = "R6 upstream";
    return 4'b0001;
  endfunction

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_cmd(input bit io, input bit mst);
    wr(5'd0, {30'd0, mst, io});
    m_io_en = io; m_mst = mst;
  endtask

  task automatic set_win(input int p, input int k, input logic [31:0] b, input logic [31:0] l);
    wr({1'b1, p[0], k[1:0], 1'b0}, b);
    wr({1'b1, p[0], k[1:0], 1'b1}, l);
    m_base[p][k] = b; m_lim[p][k] = l;
  endtask

  task automatic req_check(input int port, input bit io, input logic [31:0] a);
    logic [3:0] e;
    string tag;
    e = model(port, io, a, tag);
    @(negedge clk);
    req_valid = 1'b1; req_port = port[1:0]; req_is_io = io; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 out_valid", {31'd0, out_valid}, 32'd1);
    chk("R9 out_addr", out_addr, a);
    chk(tag, {28'd0, out_ignore, out_dest}, {28'd0, e});
    chk("R10 exclusive", {31'd0, (out_ignore ? out_dest == 3'b000 : $countones(out_dest) == 1)}, 32'd1);
  endtask

  task automatic sweep();
    logic [31:0] addrs [38];
    int n;
    n = 0;
    for (int p = 0; p < 2; p++)
      for (int k = 0; k < 3; k++) begin
        addrs[n++] = m_base[p][k] - 1;
        addrs[n++] = m_base[p][k];
        addrs[n++] = m_base[p][k] + 1;
        addrs[n++] = m_lim[p][k] - 1;
        addrs[n++] = m_lim[p][k];
        addrs[n++] = m_lim[p][k] + 1;
      end
    addrs[n++] = 32'h0;
    addrs[n++] = 32'hFFFF_FFFF;
    for (int c = 0; c < 4; c++) begin
      set_cmd(c[0], c[1]);
      for (int port = 0; port < 4; port++)
        for (int io = 0; io < 2; io++)
          for (int i = 0; i < 38; i++)
            req_check(port, io[0], addrs[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int p = 0; p < 2; p++)
      for (int k = 0; k < 3; k++) begin
        m_base[p][k] = 32'hFFFF_FFFF; m_lim[p][k] = 32'h0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset out_valid", {31'd0, out_valid}, 32'd0);

    // R1: reset windows are empty
    set_cmd(1'b1, 1'b1);
    req_check(0, 1'b0, 32'h0);
    req_check(0, 1'b0, 32'hFFFF_FFFF);
    req_check(0, 1'b1, 32'h0);
    req_check(1, 1'b0, 32'h8000_0000);
    chk("R1 reset no-hit", {31'd0, out_dest[0]}, 32'd1);

    // layout A: overlapping windows
    set_win(0, 0, 32'h0000_1000, 32'h0000_1FFF);
    set_win(0, 1, 32'h8000_0000, 32'h8FFF_FFFF);
    set_win(0, 2, 32'hC000_0000, 32'hC0FF_FFFF);
    set_win(1, 0, 32'h0000_1800, 32'h0000_2FFF);
    set_win(1, 1, 32'h8800_0000, 32'h9FFF_FFFF);
    set_win(1, 2, 32'hD000_0000, 32'hD0FF_FFFF);
    sweep();

    // R11: unmapped writes leave routing unchanged
    set_cmd(1'b1, 1'b1);
    wr(5'b00001, 32'h0);
    wr(5'b10110, 32'h0);
    wr(5'b11111, 32'hFFFF_FFFF);
    wr(5'b01000, 32'h0);
    req_check(0, 1'b0, 32'h8000_0000);
    chk("R11 unmapped write ignored", {29'd0, out_dest}, 32'd2);
    req_check(2, 1'b1, 32'h0000_1000);
    chk("R11 unmapped write ignored io", {29'd0, out_dest}, 32'd2);

    // R11: write on same cycle as request uses old value; next cycle uses new
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'd0; cfg_wdata = 32'd0;
    req_valid = 1'b1; req_port = 2'd0; req_is_io = 1'b1; req_addr = 32'h0000_1000;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R11 same-cycle write uses old", {28'd0, out_ignore, out_dest}, 32'h2);
    req_addr = 32'h0000_1004;
    @(negedge clk);
    req_valid = 1'b0;
    m_io_en = 0; m_mst = 0;
    chk("R11 next-cycle write applies", {28'd0, out_ignore, out_dest}, 32'h8);
    @(negedge clk);
    chk("R9 idle out_valid", {31'd0, out_valid}, 32'd0);

    // layout B: empty, single-address and edge windows
    set_win(0, 0, 32'h0000_4000, 32'h0000_3FFF);
    set_win(0, 1, 32'h0000_0000, 32'h0000_FFFF);
    set_win(0, 2, 32'hFFFF_0000, 32'hFFFF_FFFF);
    set_win(1, 0, 32'h0000_0000, 32'h0000_FFFF);
    set_win(1, 1, 32'h0001_0000, 32'h0001_0000);
    set_win(1, 2, 32'hF000_0000, 32'hFFFF_7FFF);
    sweep();

    // R1: empty window at its base never claims
    set_cmd(1'b1, 1'b1);
    req_check(0, 1'b1, 32'h0000_4000);
    chk("R1 empty window to s2", {29'd0, out_dest}, 32'd4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule